// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the flow-control part of the register-rename stage in an out-of-order core. Each cycle decode may present a group of up to `WIDTH` instructions, together with a per-slot destination mask, a per-slot barrier mask and a group tag. The block renames as many instructions as it can, in program order. Each instruction takes one reorder-buffer entry and one issue-queue entry, and each instruction with a destination also takes one physical register. For each resource the block keeps a free count, and commit returns entries to it through release inputs.

When a resource runs out partway through a group, the block saves the rest of that group along with a resume index and moves to a blocked state. Groups that decode sends while the stage cannot take them wait in a small FIFO skid buffer. Once resources return, the block drains the partial group and then the skid buffer, oldest first, and only after that takes new groups straight from decode. A squash from the execute stage discards all pending work. A barrier instruction holds the stage until the barrier is released.

Top module: `rn_stall_ctrl`

## Requirements
- R1: While reset is held, `state_o` reads 1 (Idle), `stall_o` is low and `out_valid_o` is low. The free counts start at `ROB_SIZE`, `IQ_SIZE` and `PREG_FREE`.
- R2: The head group is renamed in order, starting at its resume index. The block renames consecutive instructions while each one still fits. `out_first_o` gives the starting slot, `out_num_o` the count renamed (from 1 to `WIDTH`) and `out_dst_num_o` how many of those set their destination bit.
- R3: An instruction fits if the running totals stay within the available amounts: reorder-buffer and issue-queue entries (one per instruction) and physical registers (one per destination bit). The available amount of each resource is its free count plus the release input of this cycle. Each free count then becomes available minus used.
- R4: If a renaming cycle stops on a resource shortfall while instructions remain, `state_o` becomes 3 (Blocked). Nothing is renamed in Blocked. The state moves to 4 (Unblocking) after a Blocked cycle in which the next pending instruction fits.
- R5: After a stall, renaming restarts at the first instruction of the group that was not yet renamed, and `out_first_o` shows that slot.
- R6: A group that is not taken directly goes into the skid buffer. This happens while a partial group is pending, while the skid buffer is not empty, or in Blocked or BarrierStall. The partial group is renamed first, then the skid buffer in arrival order, and the order is visible on `out_tag_o`.
- R7: In Unblocking, the state becomes 0 (Running) or 1 (Idle) only when no partial group and no skid entry is left after the cycle. Otherwise it stays at 4. A new shortfall returns it to 3.
- R8: When `squash_i` is high, nothing is renamed that cycle, and the partial group, the skid buffer and any incoming group are discarded. The next state is 2 (Squashing). Squashing drops its input and is followed by 1 (Idle).
- R9: An instruction whose barrier bit is set ends renaming for that cycle once it has been renamed, and the state becomes 5 (BarrierStall). The state stays at 5 until `barrier_done_i` is high. It then moves to 4 if work is pending, or to 1 if none is.
- R10: `stall_o` is high in Blocked, Squashing and BarrierStall, and in Unblocking while the skid buffer holds at least one group. It is low in every other case.
- R11: From Running, Idle or Unblocking (when no stall, barrier or pending work applies), the next state is 0 (Running) if the cycle renamed anything and 1 (Idle) if it did not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decode group present |
| in_cnt_i | input | $clog2(WIDTH+1) | Instructions in the group, 1..WIDTH |
| in_dst_i | input | WIDTH | Per-slot destination-register flag |
| in_bar_i | input | WIDTH | Per-slot barrier flag |
| in_tag_i | input | TAG_W | Group identifier |
| stall_o | output | 1 | Stall request back to decode |
| squash_i | input | 1 | Squash from execute stage |
| barrier_done_i | input | 1 | Releases a barrier stall |
| rob_rel_i | input | $clog2(COMMIT_W+1) | Reorder-buffer entries released this cycle |
| iq_rel_i | input | $clog2(COMMIT_W+1) | Issue-queue entries released this cycle |
| preg_rel_i | input | $clog2(COMMIT_W+1) | Physical registers released this cycle |
| out_valid_o | output | 1 | Instructions renamed this cycle |
| out_first_o | output | $clog2(WIDTH+1) | First slot renamed |
| out_num_o | output | $clog2(WIDTH+1) | Number of instructions renamed |
| out_dst_num_o | output | $clog2(WIDTH+1) | Destinations allocated |
| out_tag_o | output | TAG_W | Tag of the group being renamed |
| state_o | output | 3 | Controller state code |

## Verification
A free count that drifts shows up at the ports as renaming that stops early or runs too long. This appears as a wrong `out_num_o` or a wrong move into Blocked, in the first cycle where the resource runs short. A resume index or skid pointer that is off shows up at once on `out_first_o` or `out_tag_o` when the held work is renamed. A state register that is off shows up in the same cycle on `state_o` and `stall_o`. A reference model runs every cycle alongside the design under mixed stimulus: stingy releases, decode sending while stalled, barriers and squashes. Every output is compared every cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SQUASH = 3'd2,
    ST_BLOCK  = 3'd3,
    ST_UNBLK  = 3'd4,
    ST_BARR   = 3'd5
  } rn_state_e;
endpackage

// File: rtl/rn_free_ctr.sv
module rn_free_ctr #(
  parameter int unsigned CAP   = 16,
  parameter int unsigned INIT  = 16,
  parameter int unsigned AW    = 5,
  parameter int unsigned REL_W = 3,
  parameter int unsigned USE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REL_W-1:0] rel_i,
  input  logic [USE_W-1:0] use_i,
  output logic [AW-1:0]    avail_o
);
  logic [AW-1:0] free_q;

  // releases from last commit count toward this cycle's budget
  assign avail_o = free_q + AW'(rel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= AW'(INIT);
    else         free_q <= avail_o - AW'(use_i);
  end

  a_r3_within_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= AW'(CAP));
  a_r3_no_overdraw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    AW'(use_i) <= avail_o);
endmodule

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt_ptr(wr_q);
      if (pop_i)  rd_q <= nxt_ptr(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i) |-> !full_o);
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned POS_W = 3,
  parameter int unsigned AW    = 5
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] cnt_i,
  input  logic [WIDTH-1:0] dst_i,
  input  logic [WIDTH-1:0] bar_i,
  input  logic [AW-1:0]    rob_av_i,
  input  logic [AW-1:0]    iq_av_i,
  input  logic [AW-1:0]    preg_av_i,
  output logic [POS_W-1:0] num_o,
  output logic [POS_W-1:0] dnum_o,
  output logic             bar_hit_o,
  output logic             done_o
);
  int   n_v, d_v;
  logic stop_v, bh_v;

  // in-order prefix: stop at first misfit or right after a barrier
  always_comb begin
    n_v    = 0;
    d_v    = 0;
    stop_v = 1'b0;
    bh_v   = 1'b0;
    for (int j = 0; j < int'(WIDTH); j++) begin
      if (!stop_v && j >= int'(pos_i) && j < int'(cnt_i)) begin
        if ((n_v + 1 <= int'(rob_av_i)) && (n_v + 1 <= int'(iq_av_i)) &&
            (d_v + int'(dst_i[j]) <= int'(preg_av_i))) begin
          n_v = n_v + 1;
          d_v = d_v + int'(dst_i[j]);
          if (bar_i[j]) begin
            bh_v   = 1'b1;
            stop_v = 1'b1;
          end
        end else begin
          stop_v = 1'b1;
        end
      end
    end
  end

  assign num_o     = POS_W'(n_v);
  assign dnum_o    = POS_W'(d_v);
  assign bar_hit_o = bh_v;
  assign done_o    = (int'(pos_i) + n_v == int'(cnt_i));
endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
  import rn_pkg::*;
#(
  parameter int unsigned WIDTH      = 4,
  parameter int unsigned SKID_DEPTH = 4,
  parameter int unsigned ROB_SIZE   = 16,
  parameter int unsigned IQ_SIZE    = 8,
  parameter int unsigned PREG_FREE  = 12,
  parameter int unsigned COMMIT_W   = 4,
  parameter int unsigned TAG_W      = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic [$clog2(WIDTH+1)-1:0]    in_cnt_i,
  input  logic [WIDTH-1:0]              in_dst_i,
  input  logic [WIDTH-1:0]              in_bar_i,
  input  logic [TAG_W-1:0]              in_tag_i,
  output logic                          stall_o,
  input  logic                          squash_i,
  input  logic                          barrier_done_i,
  input  logic [$clog2(COMMIT_W+1)-1:0] rob_rel_i,
  input  logic [$clog2(COMMIT_W+1)-1:0] iq_rel_i,
  input  logic [$clog2(COMMIT_W+1)-1:0] preg_rel_i,
  output logic                          out_valid_o,
  output logic [$clog2(WIDTH+1)-1:0]    out_first_o,
  output logic [$clog2(WIDTH+1)-1:0]    out_num_o,
  output logic [$clog2(WIDTH+1)-1:0]    out_dst_num_o,
  output logic [TAG_W-1:0]              out_tag_o,
  output logic [2:0]                    state_o
);
  localparam int unsigned POS_W   = $clog2(WIDTH+1);
  localparam int unsigned REL_W   = $clog2(COMMIT_W+1);
  localparam int unsigned CAP_A   = (ROB_SIZE > IQ_SIZE) ? ROB_SIZE : IQ_SIZE;
  localparam int unsigned MAX_CAP = (CAP_A > PREG_FREE) ? CAP_A : PREG_FREE;
  localparam int unsigned AW      = $clog2(MAX_CAP + COMMIT_W + 1);
  localparam int unsigned GW      = POS_W + 2*WIDTH + TAG_W;
  localparam int unsigned SC_W    = $clog2(SKID_DEPTH+1);
  localparam int unsigned NRES    = 3;

  rn_state_e st_q, st_d;

  logic             cur_vld_q, cur_vld_d;
  logic [POS_W-1:0] cur_pos_q;
  logic [GW-1:0]    cur_grp_q;

  logic             skid_empty, skid_full;
  logic [SC_W-1:0]  skid_cnt, skid_cnt_nx;
  logic [GW-1:0]    skid_dout, in_grp, head_grp;
  logic             push, pop;

  logic             ren_en, sel_cur, sel_skid, sel_in, have_head, fire, work_after;
  logic [POS_W-1:0] head_pos, h_cnt;
  logic [WIDTH-1:0] h_dst, h_bar;
  logic [TAG_W-1:0] h_tag;
  logic [POS_W-1:0] a_num, a_dnum;
  logic             a_bar, a_done;

  logic [AW-1:0]    av    [NRES];
  logic [REL_W-1:0] rel   [NRES];
  logic [POS_W-1:0] use_v [NRES];

  assign in_grp = {in_cnt_i, in_dst_i, in_bar_i, in_tag_i};

  assign ren_en = !squash_i && (st_q == ST_RUN || st_q == ST_IDLE || st_q == ST_UNBLK);

  // head priority: partial group, then oldest skid entry, then decode
  assign sel_cur   = cur_vld_q;
  assign sel_skid  = !cur_vld_q && !skid_empty;
  assign sel_in    = !cur_vld_q && skid_empty && in_valid_i && ren_en;
  assign have_head = sel_cur || sel_skid || sel_in;

  always_comb begin
    head_grp = '0;
    head_pos = '0;
    if (sel_cur) begin
      head_grp = cur_grp_q;
      head_pos = cur_pos_q;
    end else if (sel_skid) begin
      head_grp = skid_dout;
    end else if (sel_in) begin
      head_grp = in_grp;
    end
  end

  assign h_cnt = head_grp[GW-1 -: POS_W];
  assign h_dst = head_grp[2*WIDTH+TAG_W-1 -: WIDTH];
  assign h_bar = head_grp[WIDTH+TAG_W-1 -: WIDTH];
  assign h_tag = head_grp[TAG_W-1:0];

  rn_alloc #(.WIDTH(WIDTH), .POS_W(POS_W), .AW(AW)) u_alloc (
    .pos_i     (head_pos),
    .cnt_i     (h_cnt),
    .dst_i     (h_dst),
    .bar_i     (h_bar),
    .rob_av_i  (av[0]),
    .iq_av_i   (av[1]),
    .preg_av_i (av[2]),
    .num_o     (a_num),
    .dnum_o    (a_dnum),
    .bar_hit_o (a_bar),
    .done_o    (a_done)
  );

  assign fire = ren_en && have_head && (a_num != '0);

  assign rel[0]   = rob_rel_i;
  assign rel[1]   = iq_rel_i;
  assign rel[2]   = preg_rel_i;
  assign use_v[0] = fire ? a_num  : '0;
  assign use_v[1] = fire ? a_num  : '0;
  assign use_v[2] = fire ? a_dnum : '0;

  for (genvar g = 0; g < NRES; g++) begin : g_res
    localparam int unsigned CAP = (g == 0) ? ROB_SIZE : (g == 1) ? IQ_SIZE : PREG_FREE;
    rn_free_ctr #(
      .CAP(CAP), .INIT(CAP), .AW(AW), .REL_W(REL_W), .USE_W(POS_W)
    ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rel_i   (rel[g]),
      .use_i   (use_v[g]),
      .avail_o (av[g])
    );
  end

  assign push = in_valid_i && !sel_in && !squash_i && (st_q != ST_SQUASH);
  assign pop  = ren_en && sel_skid;

  rn_skid_fifo #(.DW(GW), .DEPTH(SKID_DEPTH), .CW(SC_W)) u_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (squash_i),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (in_grp),
    .dout_o  (skid_dout),
    .empty_o (skid_empty),
    .full_o  (skid_full),
    .cnt_o   (skid_cnt)
  );

  always_comb begin
    cur_vld_d = cur_vld_q;
    if (squash_i)                 cur_vld_d = 1'b0;
    else if (ren_en && have_head) cur_vld_d = !a_done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_vld_q <= 1'b0;
      cur_pos_q <= '0;
      cur_grp_q <= '0;
    end else begin
      cur_vld_q <= cur_vld_d;
      if (!squash_i && ren_en && have_head && !a_done) begin
        cur_grp_q <= head_grp;
        cur_pos_q <= head_pos + a_num;
      end
    end
  end

  assign skid_cnt_nx = squash_i ? '0 : skid_cnt + SC_W'(push) - SC_W'(pop);
  assign work_after  = cur_vld_d || (skid_cnt_nx != '0);

  always_comb begin
    st_d = st_q;
    if (squash_i) begin
      st_d = ST_SQUASH;
    end else begin
      unique case (st_q)
        ST_SQUASH: st_d = ST_IDLE;
        ST_BLOCK:  st_d = (!have_head || a_num != '0) ? ST_UNBLK : ST_BLOCK;
        ST_BARR:   st_d = barrier_done_i ? (work_after ? ST_UNBLK : ST_IDLE) : ST_BARR;
        default: begin
          if (fire && a_bar)              st_d = ST_BARR;
          else if (have_head && !a_done)  st_d = ST_BLOCK;
          else if (work_after)            st_d = ST_UNBLK;
          else if (fire)                  st_d = ST_RUN;
          else                            st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign stall_o = (st_q == ST_BLOCK) || (st_q == ST_SQUASH) || (st_q == ST_BARR) ||
                   ((st_q == ST_UNBLK) && !skid_empty);

  assign out_valid_o   = fire;
  assign out_first_o   = head_pos;
  assign out_num_o     = a_num;
  assign out_dst_num_o = a_dnum;
  assign out_tag_o     = h_tag;
  assign state_o       = st_q;

  a_r8_squash_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> (st_q == ST_SQUASH));
  a_r8_squash_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SQUASH && !squash_i) |=> (st_q == ST_IDLE));
  a_r8_no_out_on_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |-> !out_valid_o);
  a_r4_no_rename_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BLOCK) |-> !out_valid_o);
  a_r9_barrier_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BARR && !barrier_done_i && !squash_i) |=> (st_q == ST_BARR));
  a_r2_out_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(out_first_o) + int'(out_num_o) <= int'(WIDTH)));
  a_r2_cnt_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (in_cnt_i != '0 && int'(in_cnt_i) <= int'(WIDTH)));
  a_r6_skid_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skid_full && !pop && !squash_i) |-> !push);
endmodule

// File: tb/tb_rn_stall_ctrl.sv
module tb_rn_stall_ctrl;
  localparam int W     = 4;
  localparam int SKID  = 4;
  localparam int ROB   = 16;
  localparam int IQ    = 8;
  localparam int PREG  = 12;
  localparam int CW    = 4;
  localparam int TAG_W = 4;
  localparam int PW    = $clog2(W+1);
  localparam int RW    = $clog2(CW+1);
  localparam int PHASE_LEN = 1500;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [PW-1:0] in_cnt_i = '0;
  logic [W-1:0] in_dst_i = '0, in_bar_i = '0;
  logic [TAG_W-1:0] in_tag_i = '0;
  logic squash_i = 1'b0, barrier_done_i = 1'b0;
  logic [RW-1:0] rob_rel_i = '0, iq_rel_i = '0, preg_rel_i = '0;
  logic stall_o, out_valid_o;
  logic [PW-1:0] out_first_o, out_num_o, out_dst_num_o;
  logic [TAG_W-1:0] out_tag_o;
  logic [2:0] state_o;

  always #5 clk = ~clk;

  rn_stall_ctrl #(
    .WIDTH(W), .SKID_DEPTH(SKID), .ROB_SIZE(ROB), .IQ_SIZE(IQ),
    .PREG_FREE(PREG), .COMMIT_W(CW), .TAG_W(TAG_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_cnt_i(in_cnt_i),
    .in_dst_i(in_dst_i), .in_bar_i(in_bar_i), .in_tag_i(in_tag_i), .stall_o(stall_o),
    .squash_i(squash_i), .barrier_done_i(barrier_done_i), .rob_rel_i(rob_rel_i),
    .iq_rel_i(iq_rel_i), .preg_rel_i(preg_rel_i), .out_valid_o(out_valid_o),
    .out_first_o(out_first_o), .out_num_o(out_num_o), .out_dst_num_o(out_dst_num_o),
    .out_tag_o(out_tag_o), .state_o(state_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  // reference model state
  int m_st = 1;
  bit c_vld = 0;
  int c_pos = 0, c_cnt = 0;
  logic [W-1:0] c_dst = '0, c_bar = '0;
  logic [TAG_W-1:0] c_tag = '0;
  int q_cnt [SKID];
  logic [W-1:0] q_dst [SKID], q_bar [SKID];
  logic [TAG_W-1:0] q_tag [SKID];
  int q_rd = 0, q_n = 0;
  int f_rob = ROB, f_iq = IQ, f_preg = PREG;
  logic [31:0] seed = 32'h1234_5678;
  logic [TAG_W-1:0] tag_ctr = '0;

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed[30:0]);
  endfunction

  function automatic string st_req(int s);
    case (s)
      2: return "R8";
      3: return "R4";
      4: return "R7";
      5: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic bit m_stall();
    return (m_st == 3) || (m_st == 2) || (m_st == 5) || (m_st == 4 && q_n > 0);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit ren, s_cur, s_skid, s_in, have, stop, bh, done, e_valid, push, pop, work;
    int hpos, hcnt, n, nd, ar, ai, ap, ns;
    logic [W-1:0] hdst, hbar;
    logic [TAG_W-1:0] htag;
    ren    = !squash_i && (m_st == 0 || m_st == 1 || m_st == 4);
    s_cur  = c_vld;
    s_skid = !c_vld && q_n > 0;
    s_in   = !c_vld && q_n == 0 && in_valid_i && ren;
    have   = s_cur || s_skid || s_in;
    hpos = 0; hcnt = 0; hdst = '0; hbar = '0; htag = '0;
    if (s_cur) begin
      hpos = c_pos; hcnt = c_cnt; hdst = c_dst; hbar = c_bar; htag = c_tag;
    end else if (s_skid) begin
      hcnt = q_cnt[q_rd]; hdst = q_dst[q_rd]; hbar = q_bar[q_rd]; htag = q_tag[q_rd];
    end else if (s_in) begin
      hcnt = int'(in_cnt_i); hdst = in_dst_i; hbar = in_bar_i; htag = in_tag_i;
    end
    ar = f_rob + int'(rob_rel_i);
    ai = f_iq + int'(iq_rel_i);
    ap = f_preg + int'(preg_rel_i);
    n = 0; nd = 0; stop = 0; bh = 0;
    for (int j = hpos; j < hcnt; j++) begin
      if (!stop) begin
        if (n + 1 <= ar && n + 1 <= ai && nd + int'(hdst[j]) <= ap) begin
          n++;
          nd += int'(hdst[j]);
          if (hbar[j]) begin bh = 1; stop = 1; end
        end else stop = 1;
      end
    end
    done    = (hpos + n == hcnt);
    e_valid = ren && have && n > 0;

    chk(int'(state_o) == m_st, st_req(m_st), "state_o", int'(state_o), m_st);
    chk(stall_o == m_stall(), "R10", "stall_o", int'(stall_o), int'(m_stall()));
    chk(out_valid_o == e_valid, "R3", "out_valid_o", int'(out_valid_o), int'(e_valid));
    if (e_valid) begin
      chk(int'(out_num_o) == n, "R2", "out_num_o", int'(out_num_o), n);
      chk(int'(out_dst_num_o) == nd, "R2", "out_dst_num_o", int'(out_dst_num_o), nd);
      chk(int'(out_first_o) == hpos, "R5", "out_first_o", int'(out_first_o), hpos);
      chk(out_tag_o == htag, "R6", "out_tag_o", int'(out_tag_o), int'(htag));
    end

    // model update
    f_rob  = ar - (e_valid ? n : 0);
    f_iq   = ai - (e_valid ? n : 0);
    f_preg = ap - (e_valid ? nd : 0);
    push = in_valid_i && !s_in && !squash_i && m_st != 2;
    pop  = ren && s_skid;
    if (squash_i) begin
      c_vld = 0; q_n = 0; q_rd = 0;
    end else begin
      if (ren && have) begin
        if (done) c_vld = 0;
        else begin
          c_vld = 1; c_pos = hpos + n; c_cnt = hcnt;
          c_dst = hdst; c_bar = hbar; c_tag = htag;
        end
      end
      if (pop) begin q_rd = (q_rd + 1) % SKID; q_n--; end
      if (push) begin
        q_cnt[(q_rd + q_n) % SKID] = int'(in_cnt_i);
        q_dst[(q_rd + q_n) % SKID] = in_dst_i;
        q_bar[(q_rd + q_n) % SKID] = in_bar_i;
        q_tag[(q_rd + q_n) % SKID] = in_tag_i;
        q_n++;
      end
    end
    work = c_vld || q_n > 0;
    if (squash_i) ns = 2;
    else case (m_st)
      2: ns = 1;
      3: ns = (!have || n > 0) ? 4 : 3;
      5: ns = barrier_done_i ? (work ? 4 : 1) : 5;
      default: begin
        if (e_valid && bh)      ns = 5;
        else if (have && !done) ns = 3;
        else if (work)          ns = 4;
        else if (e_valid)       ns = 0;
        else                    ns = 1;
      end
    endcase
    m_st = ns;
  endtask

  function automatic int clamp_rel(int r, int cap, int fr);
    return (r > cap - fr) ? cap - fr : r;
  endfunction

  task automatic drive(int ph);
    bit allow, late;
    int c, r;
    late  = (ph == 1 || ph == 3) && (rnd() % 2 == 0);
    allow = !m_stall() || (late && q_n < SKID);
    if (allow && rnd() % 4 != 0) begin
      c = 1 + rnd() % W;
      in_valid_i = 1'b1;
      in_cnt_i   = PW'(c);
      in_dst_i   = W'(rnd());
      in_bar_i   = '0;
      if (ph != 0 && rnd() % 6 == 0) in_bar_i = W'(1 << (rnd() % c));
      in_tag_i   = tag_ctr;
      tag_ctr    = tag_ctr + 1'b1;
    end else begin
      in_valid_i = 1'b0;
      in_cnt_i   = '0;
      in_dst_i   = '0;
      in_bar_i   = '0;
      in_tag_i   = '0;
    end
    squash_i       = (ph >= 2) && (rnd() % 20 == 0);
    barrier_done_i = (ph == 3) ? (rnd() % 8 == 0) : (rnd() % 3 == 0);
    r = rnd() % (CW + 1);
    if (ph == 1 && rnd() % 4 != 0) r = 0;
    rob_rel_i = RW'(clamp_rel(r, ROB, f_rob));
    r = rnd() % (CW + 1);
    if (ph == 1 && rnd() % 4 != 0) r = 0;
    iq_rel_i = RW'(clamp_rel(r, IQ, f_iq));
    r = rnd() % (CW + 1);
    if (ph != 0 && rnd() % 3 != 0) r = 0;
    preg_rel_i = RW'(clamp_rel(r, PREG, f_preg));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(state_o == 3'd1, "R1", "reset state_o", int'(state_o), 1);
    chk(stall_o == 1'b0, "R1", "reset stall_o", int'(stall_o), 0);
    chk(out_valid_o == 1'b0, "R1", "reset out_valid_o", int'(out_valid_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int ph = 0; ph < 4; ph++) begin
      for (int cyc = 0; cyc < PHASE_LEN; cyc++) begin
        @(negedge clk);
        drive(ph);
        #1;
        step();
      end
    end
    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(10 * (4 * PHASE_LEN + 200));
    if (!done_run) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule